// File: doc/BRIEF.md
# Configurable Registered ROM Read Path

This block is the read side of a registered read-only memory. It has a word array and an edge-triggered output register. A three-bit mode word sits in front of them and sets how the address is taken in and how the output enable behaves. Each rising clock edge loads the word at the current effective address into the output register. The outputs then present that register. An active-low enable controls whether they drive. Real tri-state pins are modelled by an `out_drive` flag: while the flag is low, the data bus is forced to zero.

The address can take one of two paths. In the flow-through path the address goes straight to the array and the latch-enable pin is ignored. In the latched path, the address passes while latch-enable is asserted. A holding register keeps the last value taken while latch-enable was asserted and supplies it after deassertion, even if the address pins move. The polarity of latch-enable can be chosen. The enable can act on the outputs at once, or it can be sampled on the clock edge.

A load port fills the array and the mode word for simulation. The mode word lives one location past the last data word. With the default `ADDR_W` of 11, the data words are at load addresses 0x000 to 0x7FF and the mode word is at 0x800. With `ADDR_W` = 15 the array holds 32768 bytes and the mode word is at 0x8000. The default is kept smaller so that the elaborated array stays modest.

Top module: `reg_rom_read`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits. A load with `load_en` high and `load_addr[ADDR_W]` = 0 writes `load_data` into word `load_addr[ADDR_W-1:0]` at the clock edge.
- R2: On every rising clock edge the word at the effective address is captured in the output register. `out_data` shows it from that edge on, while the outputs drive.
- R3: A load to address exactly 2^ADDR_W writes the mode word. Bit 0 is the enable mode (0 = immediate, 1 = clock-sampled). Bit 1 is the address mode (0 = flow-through, 1 = latched). Bit 2 is the latch-enable polarity (0 = active high, 1 = active low). Bits 7..3 are ignored.
- R4: In flow-through mode the effective address equals `addr_in`, whatever the level of `ale`.
- R5: In latched mode, the effective address follows `addr_in` while latch-enable is asserted, and a holding register takes `addr_in` on every edge where it is asserted. While latch-enable is deasserted, the effective address is the value held, and changes on `addr_in` have no effect.
- R6: Latch-enable is asserted when `ale` = 1 with polarity bit 0, and when `ale` = 0 with polarity bit 1.
- R7: In immediate enable mode, `out_drive` equals the inverse of `en_n` at all times, with no clock edge needed.
- R8: In clock-sampled enable mode, `out_drive` equals the inverse of `en_n` as sampled at the most recent rising edge. Changes of `en_n` between edges have no effect.
- R9: While `out_drive` is 0, `out_data` is all zeros.
- R10: Loads to addresses above 2^ADDR_W change neither the mode word nor any array word.
- R11: A synchronous active-high `rst` clears the output register to zero and returns the mode word to all zeros. It also clears the holding register and sets the sampled enable to the disabled state. It does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W (11) | Read address |
| ale | input | 1 | Latch-enable, polarity set by mode bit 2 |
| en_n | input | 1 | Output enable, active low |
| load_en | input | 1 | Load strobe for array and mode word |
| load_addr | input | ADDR_W+1 (12) | Load address; 2^ADDR_W selects the mode word |
| load_data | input | DATA_W (8) | Load data |
| out_data | output | DATA_W (8) | Registered read data, zero when not driving |
| out_drive | output | 1 | High when the outputs would drive |

## Verification
The bench runs the same six-step address and enable sequence under all eight mode words. Flow-through and latched modes are told apart by an address that moves while latch-enable is inactive. Only the latched path keeps returning the old word. Polarity is told apart because the `ale` pin is driven at opposite levels for the same logical sequence. After each edge the bench also flips `en_n` between edges. This separates an immediate enable, which follows the flip, from a sampled one, which does not. Directed cases then cover the reset state, the reserved mode bits, and loads just past the mode location.

// File: rtl/rrom_pkg.sv
package rrom_pkg;

    // Bit positions inside the mode word (decoded by rrom_store)
    localparam int MODE_EN_BIT  = 0;
    localparam int MODE_ADR_BIT = 1;
    localparam int MODE_POL_BIT = 2;

    typedef enum logic {
        EN_IMMEDIATE = 1'b0,
        EN_CLOCKED   = 1'b1
    } en_mode_e;

    typedef enum logic {
        ADDR_FLOW  = 1'b0,
        ADDR_LATCH = 1'b1
    } addr_mode_e;

    typedef struct packed {
        logic       le_low;
        addr_mode_e amode;
        en_mode_e   emode;
    } rrom_mode_t;

    localparam rrom_mode_t MODE_DEFAULT = '{le_low: 1'b0, amode: ADDR_FLOW, emode: EN_IMMEDIATE};

    function automatic rrom_mode_t decode_mode(input logic [2:0] b);
        rrom_mode_t m;
        m.le_low = b[MODE_POL_BIT];
        m.amode  = addr_mode_e'(b[MODE_ADR_BIT]);
        m.emode  = en_mode_e'(b[MODE_EN_BIT]);
        return m;
    endfunction

endpackage

// File: rtl/rrom_store.sv
module rrom_store
    import rrom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W:0]   load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output rrom_mode_t        mode
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] MODE_LOC = {1'b1, {ADDR_W{1'b0}}};

    logic [DATA_W-1:0] mem [DEPTH];
    rrom_mode_t        mode_q;

    logic word_wr, mode_wr;
    assign word_wr = load_en && !load_addr[ADDR_W];
    assign mode_wr = load_en && (load_addr == MODE_LOC);

    always_ff @(posedge clk) begin
        if (word_wr) mem[load_addr[ADDR_W-1:0]] <= load_data;
    end

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= MODE_DEFAULT;
        else if (mode_wr) mode_q <= decode_mode(load_data[2:0]);
    end

    assign rd_word = mem[rd_addr];
    assign mode    = mode_q;

    // R11
    mode_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mode_q == MODE_DEFAULT);

    // R10
    high_load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && load_addr > MODE_LOC) |=> $stable(mode_q));

endmodule

// File: rtl/rrom_addr_path.sv
module rrom_addr_path
    import rrom_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ale,
    input  addr_mode_e        amode,
    input  logic              le_low,
    output logic [ADDR_W-1:0] eff_addr
);
    logic              le_act;
    logic [ADDR_W-1:0] held_q;

    assign le_act = ale ^ le_low;

    always_ff @(posedge clk) begin
        if (rst)         held_q <= '0;
        else if (le_act) held_q <= addr_in;
    end

    always_comb begin
        if (amode == ADDR_LATCH && !le_act) eff_addr = held_q;
        else                                eff_addr = addr_in;
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(le_act)) |-> $stable(held_q));

    // R4
    flow_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (amode == ADDR_FLOW) |-> eff_addr == addr_in);

endmodule

// File: rtl/rrom_out_stage.sv
module rrom_out_stage
    import rrom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word_in,
    input  en_mode_e          emode,
    input  logic              en_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_drive
);
    logic [DATA_W-1:0] word_q;
    logic              en_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            en_n_q <= 1'b1;
        end else begin
            word_q <= word_in;
            en_n_q <= en_n;
        end
    end

    always_comb begin
        out_drive = (emode == EN_CLOCKED) ? !en_n_q : !en_n;
        out_data  = out_drive ? word_q : '0;
    end

    // R2
    word_load_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> word_q == $past(word_in));

    // R8
    sampled_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && emode == EN_CLOCKED) |-> out_drive == !$past(en_n));

    // R9
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !out_drive |-> out_data == '0);

endmodule

// File: rtl/reg_rom_read.sv
module reg_rom_read
    import rrom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ale,
    input  logic              en_n,
    input  logic              load_en,
    input  logic [ADDR_W:0]   load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_drive
);
    rrom_mode_t        mode;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] rd_word;

    rrom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .rd_addr   (eff_addr),
        .rd_word   (rd_word),
        .mode      (mode)
    );

    rrom_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .addr_in  (addr_in),
        .ale      (ale),
        .amode    (mode.amode),
        .le_low   (mode.le_low),
        .eff_addr (eff_addr)
    );

    rrom_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .word_in   (rd_word),
        .emode     (mode.emode),
        .en_n      (en_n),
        .out_data  (out_data),
        .out_drive (out_drive)
    );

    // R11
    out_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && out_drive) |-> out_data == '0);

endmodule

// File: tb/test_reg_rom_read.sv
module test_reg_rom_read;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              le_on;   // logical latch-enable, before polarity
        logic              en_n;
    } step_t;

    localparam int NSTEP = 6;
    localparam step_t STEPS [NSTEP] = '{
        '{addr: 11'd10, le_on: 1'b1, en_n: 1'b0},
        '{addr: 11'd20, le_on: 1'b1, en_n: 1'b0},
        '{addr: 11'd20, le_on: 1'b0, en_n: 1'b0},
        '{addr: 11'd33, le_on: 1'b0, en_n: 1'b0},
        '{addr: 11'd44, le_on: 1'b0, en_n: 1'b1},
        '{addr: 11'd55, le_on: 1'b1, en_n: 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              ale = 1'b0;
    logic              en_n = 1'b0;
    logic              load_en = 1'b0;
    logic [ADDR_W:0]   load_addr = '0;
    logic [DATA_W-1:0] load_data = '0;
    logic [DATA_W-1:0] out_data;
    logic              out_drive;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    reg_rom_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_reg_rom_read (
        .clk(clk), .rst(rst), .addr_in(addr_in), .ale(ale), .en_n(en_n),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .out_data(out_data), .out_drive(out_drive)
    );

    function automatic logic [DATA_W-1:0] pat(input int a);
        int v;
        v = a * 7 + (a >> 8) * 13 + 3;
        return v[DATA_W-1:0];
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic load_word(input logic [ADDR_W:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // R11: reset state, then defaults (immediate enable) visible at the ports
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ale = 1'b0; en_n = 1'b0; addr_in = '0;
        @(posedge clk); #1;
        check("R11", "data after reset", int'(out_data), 0);
        check("R11", "drive after reset", int'(out_drive), 1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [ADDR_W-1:0] held;
        logic [ADDR_W-1:0] exp_a;
        logic              exp_drv;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: fill the array
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = (ADDR_W+1)'(a); load_data = pat(a);
        end
        @(negedge clk); load_en = 1'b0;

        for (int m = 0; m < 8; m++) begin
            logic [2:0] md;
            md = 3'(m);
            do_reset();
            // R3: reserved bits set, must not matter
            load_word({1'b1, {ADDR_W{1'b0}}}, {5'b10110, md});
            held = '0;
            for (int s = 0; s < NSTEP; s++) begin
                @(negedge clk);
                addr_in = STEPS[s].addr;
                ale     = STEPS[s].le_on ^ md[2];   // R6
                en_n    = STEPS[s].en_n;
                @(posedge clk); #1;
                exp_a   = (md[1] && !STEPS[s].le_on) ? held : STEPS[s].addr;
                if (STEPS[s].le_on) held = STEPS[s].addr;
                exp_drv = !STEPS[s].en_n;
                // R2 R4 R5 R9
                check(md[1] ? "R5" : "R4", $sformatf("mode %0d step %0d data", m, s),
                      int'(out_data), exp_drv ? int'(pat(int'(exp_a))) : 0);
                // mid-cycle flip of the enable: R7 follows, R8 ignores
                en_n = ~en_n;
                #1;
                check(md[0] ? "R8" : "R7", $sformatf("mode %0d step %0d drive", m, s),
                      int'(out_drive), md[0] ? int'(exp_drv) : int'(!en_n));
            end
        end

        // R10: loads above the mode location are ignored
        do_reset();
        load_word({1'b1, {ADDR_W{1'b0}}} + 1, 8'h07);
        load_word({(ADDR_W+1){1'b1}}, 8'h07);
        @(negedge clk); addr_in = 11'd5; ale = 1'b1; en_n = 1'b0;
        @(posedge clk); #1;
        check("R10", "word 5", int'(out_data), int'(pat(5)));
        @(negedge clk); addr_in = 11'd1; ale = 1'b0;
        @(posedge clk); #1;
        check("R10", "flow mode kept, word 1 untouched", int'(out_data), int'(pat(1)));
        en_n = 1'b1; #1;
        check("R10", "immediate enable kept", int'(out_drive), 0);
        check("R9", "zero bus when off", int'(out_data), 0);

        finish_run();
    end
endmodule